// File: doc/BRIEF.md
# Channel-Select Multiplexer Control with Interrupt Aggregation

This block holds the control state for a four-way downstream bus multiplexer and collects the interrupt lines of the four downstream segments. A byte-wide register port stands in for the serial slave front end. A byte written to the port selects one downstream segment, or none. The block then drives a one-hot set of segment-enable outputs.

Each segment has one active-low interrupt line. The lines are synchronized and then merged into a single shared interrupt, modelled as an open-drain pull-down enable. A read of the same register returns the written selection in its low nibble. The upper nibble carries the live status of every segment's interrupt, so software can find the requesting segment, select it and service it. The status is never latched. It follows the pins, with a fixed synchronizer delay.

Top module: `chsel_irq_ctrl`

## Requirements
- R1: While reset is asserted, and until the first write after it, the read value is 0x00 when all interrupt pins are high. The enables are all 0 and the interrupt pull-down is off.
- R2: A stored value whose bit 2 is 0 enables no segment, whatever bits 1:0 hold.
- R3: When stored bit 2 is 1, bits 1:0 pick the segment: 0 gives ch_en_o[0], 1 gives ch_en_o[1], 2 gives ch_en_o[2] and 3 gives ch_en_o[3].
- R4: Bits 7:4 of a written byte have no effect on the enables or on any read bit.
- R5: Bits 3:0 of the read value return bits 3:0 of the last write. A write presented with wr_en high is visible right after the next rising clock edge. Without wr_en the stored value holds.
- R6: Read bits 7, 6, 5 and 4 report segments 3, 2, 1 and 0. A bit reads 1 when that segment's pin is low. The status is the pin level sampled at the second rising edge before the read, through a two-stage synchronizer.
- R7: The interrupt pull-down enable is 1 whenever any status bit is 1, whether or not that segment is selected.
- R8: Interrupts are level-based. Once all pins have been high for two rising edges, the pull-down enable returns to 0 with no write or read needed.
- R9: Several status bits may be 1 at once, each following only its own pin.
- R10: At most one segment enable is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Byte to write; only bits 3:0 are kept |
| rd_data | output | 8 | Read value: {status[3:0], stored select bits[3:0]} |
| irq_n_i | input | 4 | Active-low interrupt pin per segment, asynchronous |
| ch_en_o | output | 4 | One-hot segment enables |
| irq_drive_low_o | output | 1 | 1 pulls the shared interrupt line low; 0 releases it |

## Verification
The assertions allow the interrupt pins to change at any moment relative to the clock, because every use of them goes through the synchronizer. They do require wr_data to be stable and free of unknowns whenever wr_en is high at a clock edge. The stimulus follows both rules. It changes every input on the falling clock edge, so written bytes and pin levels are settled at each rising edge. It still toggles the pins in single-cycle pulses as well as long holds, which exercises the synchronizer delay.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  parameter int unsigned CH_NUM  = 4;
  parameter int unsigned BYTE_W  = 8;
  localparam int unsigned CODE_W = $clog2(CH_NUM);
  localparam int unsigned SEL_W  = BYTE_W - CH_NUM;
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, meta_d, hold_q, hold_d;

  always_comb begin
    meta_d = async_i;
    hold_d = meta_q;
  end

  // reset to the released (high) level so no interrupt is seen in reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      hold_q <= '1;
    end else begin
      meta_q <= meta_d;
      hold_q <= hold_d;
    end
  end

  assign sync_o = hold_q;

  // R6: second stage follows the first by exactly one edge
  a_r6_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q == $past(meta_q));
endmodule

// File: rtl/chsel_reg.sv
module chsel_reg #(
  parameter int unsigned CH_NUM = 4,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned CODE_W = $clog2(CH_NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  output logic [SEL_W-1:0]  sel_q,
  output logic [CH_NUM-1:0] ch_en
);
  logic [SEL_W-1:0] sel_d;
  logic             on_bit;
  logic [CODE_W-1:0] code;

  always_comb begin
    sel_d = sel_q;
    if (wr_en) sel_d = wr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign on_bit = sel_q[CODE_W];
  assign code   = sel_q[CODE_W-1:0];

  for (genvar g = 0; g < CH_NUM; g++) begin : g_dec
    assign ch_en[g] = on_bit && (code == CODE_W'(g));
  end

  // R5: a strobed write is stored at the next edge, otherwise held
  a_r5_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sel_q == $past(wr_sel));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sel_q));
endmodule

// File: rtl/chsel_irq_agg.sv
module chsel_irq_agg #(
  parameter int unsigned CH_NUM = 4
) (
  input  logic [CH_NUM-1:0] irq_sync_n,
  output logic [CH_NUM-1:0] status,
  output logic              drive_low
);
  always_comb begin
    status    = ~irq_sync_n;
    drive_low = |status;
  end
endmodule

// File: rtl/chsel_irq_ctrl.sv
module chsel_irq_ctrl
  import chsel_pkg::*;
#(
  parameter int unsigned NUM_CH = CH_NUM,
  parameter int unsigned DATA_W = BYTE_W,
  localparam int unsigned LOW_W = DATA_W - NUM_CH,
  localparam int unsigned CW    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] irq_n_i,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic              irq_drive_low_o
);
  logic [NUM_CH-1:0] irq_sync_n, status;
  logic [LOW_W-1:0]  sel_q;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:LOW_W];

  chsel_sync #(.WIDTH(NUM_CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(irq_n_i), .sync_o(irq_sync_n));

  chsel_reg #(.CH_NUM(NUM_CH), .SEL_W(LOW_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_data[LOW_W-1:0]),
    .sel_q(sel_q), .ch_en(ch_en_o));

  chsel_irq_agg #(.CH_NUM(NUM_CH)) u_agg (
    .irq_sync_n(irq_sync_n), .status(status), .drive_low(irq_drive_low_o));

  assign rd_data = {status, sel_q};

  // R10: never more than one segment enabled
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_en_o));
  // R2: enable bit clear means no segment
  a_r2_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[CW] |-> ch_en_o == '0);
  // R3: enable bit set means the coded segment is on
  a_r3_select: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[CW] |-> ch_en_o[rd_data[CW-1:0]]);
  // R7: any pending status pulls the shared line low
  a_r7_any_pulls: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[DATA_W-1:LOW_W] != '0) |-> irq_drive_low_o);
  // R8: no pending status releases the line
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[DATA_W-1:LOW_W] == '0) |-> !irq_drive_low_o);
  // R4: read low bits come from the write, never from its upper bits
  a_r4_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[LOW_W-1:0] == $past(wr_data[LOW_W-1:0]));
endmodule

// File: tb/chsel_irq_ctrl_test.sv
module chsel_irq_ctrl_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [3:0] irq_n_i;
  logic [3:0] ch_en_o;
  logic       irq_drive_low_o;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural model state
  logic [3:0] m_sel;
  logic [3:0] m_pins[$];

  always #(PERIOD/2) clk = ~clk;

  chsel_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_n_i(irq_n_i), .ch_en_o(ch_en_o),
    .irq_drive_low_o(irq_drive_low_o));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [3:0] st, en;
    st = ~m_pins[0];
    en = m_sel[2] ? (4'b0001 << m_sel[1:0]) : 4'b0000;
    // R6 R9: status bit per segment, bit 4 = segment 0
    chk("R6", {4'h0, rd_data[7:4]}, {4'h0, st});
    // R5 R4: low nibble echoes the stored write
    chk("R5", {4'h0, rd_data[3:0]}, {4'h0, m_sel});
    // R2 R3 R10: decoded enables
    chk("R3", {4'h0, ch_en_o}, {4'h0, en});
    // R7 R8: shared line
    chk("R7", {7'h0, irq_drive_low_o}, {7'h0, (st != 4'h0)});
  endtask

  task automatic cyc(input logic w, input logic [7:0] d, input logic [3:0] p);
    wr_en = w; wr_data = d; irq_n_i = p;
    @(posedge clk);
    m_pins.push_back(p);
    void'(m_pins.pop_front());
    if (w) m_sel = d[3:0];
    #(PERIOD/4);
    compare();
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; irq_n_i = 4'hF;
    m_sel = 4'h0; m_pins = '{4'hF, 4'hF};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", rd_data, 8'h00);
    chk("R1", {4'h0, ch_en_o}, 8'h00);
    chk("R1", {7'h0, irq_drive_low_o}, 8'h00);
    rst_n = 1'b1;
    cyc(0, 8'h00, 4'hF);
    chk("R1", rd_data, 8'h00);
    // R3: each segment code
    for (int c = 0; c < 4; c++) begin
      cyc(1, 8'h04 | 8'(c), 4'hF);
      chk("R3", {4'h0, ch_en_o}, 8'(1 << c));
    end
    // R2: bit 2 clear deselects even with code bits set
    cyc(1, 8'h0B, 4'hF);
    chk("R2", {4'h0, ch_en_o}, 8'h00);
    chk("R5", rd_data, 8'h0B);
    // R4: upper write bits ignored
    cyc(1, 8'hF6, 4'hF);
    chk("R4", rd_data, 8'h06);
    chk("R4", {4'h0, ch_en_o}, 8'h04);
    // R5: no strobe holds the value
    cyc(0, 8'h05, 4'hF);
    chk("R5", rd_data, 8'h06);
    // R6 R7: unselected segment 0 interrupt, two-edge latency
    cyc(0, 8'h00, 4'hE);
    chk("R6", {7'h0, irq_drive_low_o}, 8'h00);
    cyc(0, 8'h00, 4'hE);
    chk("R7", rd_data, 8'h16);
    chk("R7", {7'h0, irq_drive_low_o}, 8'h01);
    // R9: segments 1 and 2 together
    cyc(0, 8'h00, 4'h9);
    cyc(0, 8'h00, 4'h9);
    chk("R9", rd_data, 8'h66);
    // R8: release, line goes high after two edges
    cyc(0, 8'h00, 4'hF);
    cyc(0, 8'h00, 4'hF);
    chk("R8", {7'h0, irq_drive_low_o}, 8'h00);
    chk("R8", rd_data, 8'h06);
    // mixed traffic compared every clock against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] & r[1], r[15:8], (i % 7 < 3) ? r[19:16] : 4'hF);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule